// File: doc/BRIEF.md
# Supply Voltage Detector Sampling Controller

This block runs an on-chip supply voltage comparator and keeps its verdict in a status latch that software reads. Software writes two mode bits in one register write: a heavy-load bit and a detector-enable bit. The heavy-load bit drives a select output that moves the display regulator into its high-stability mode. The block powers the comparator whenever any reason to sample exists. It times how long the comparator has been powered, and it copies the comparator output into the latch at two kinds of moment.

The first moment is a single capture at the end of the first instruction after heavy-load mode is entered. The second is every 2 Hz timer strobe while heavy-load mode is on. Once a low supply has been latched, the hardware keeps the comparator powered and keeps capturing on the 2 Hz strobe, even if software has cleared both bits. This continues until a capture shows the supply has recovered. Every capture also records whether the comparator had been powered for the full settling window, so software can reject early results.

Top module: `supply_sense_top`

## Requirements
- R1: After reset the latched level `statusLow`, the flag `statusValid`, the regulator select `hiStabSel` and the comparator power `cmpPower` are all 0 (0 in `statusLow` means supply normal).
- R2: A cycle with `cfgWrEn`=1 loads `cfgHeavyLoad` and `cfgDetEn` into the mode bits. `hiStabSel` equals the stored heavy-load bit from the cycle after the write.
- R3: A write that takes the heavy-load bit from 0 to 1 arms one capture. The first `instrDone` pulse in a later cycle copies `cmpIn` into `statusLow`. An `instrDone` in the same cycle as the write does not fire it.
- R4: An armed capture fires only once. Later `instrDone` pulses leave `statusLow` unchanged.
- R5: While the heavy-load bit is 1, each `tick2Hz` pulse copies `cmpIn` into `statusLow`.
- R6: A `tick2Hz` pulse is ignored when the heavy-load bit is 0 and `statusLow` is 0. This holds even when the detector-enable bit is 1.
- R7: While `statusLow` is 1, `cmpPower` stays 1 and each `tick2Hz` captures `cmpIn`, whatever the mode bits are. This continues until a capture stores 0.
- R8: `cmpPower` is 1 exactly when the detector-enable bit, the heavy-load bit or `statusLow` is 1.
- R9: A capture sets `statusValid` to 1 only if `cmpPower` had been 1 for at least `SETTLE_CYCLES` clock cycles before the capturing edge. Otherwise the capture sets `statusValid` to 0.
- R10: When `cmpPower` falls, the settling count restarts from zero. A capture soon after power returns is marked not valid.
- R11: An armed capture and a `tick2Hz` in the same cycle perform one latch write, and the arm is consumed.
- R12: Writing the heavy-load bit back to 0 before the armed capture fires cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgHeavyLoad | input | 1 | Heavy-load bit write data |
| cfgDetEn | input | 1 | Detector-enable bit write data |
| instrDone | input | 1 | One-cycle pulse at the end of each instruction |
| tick2Hz | input | 1 | One-cycle 2 Hz strobe from the clock timer |
| cmpIn | input | 1 | Comparator output, 1 = supply below threshold |
| cmpPower | output | 1 | Comparator enable |
| hiStabSel | output | 1 | Regulator high-stability select |
| statusLow | output | 1 | Latched detection result |
| statusValid | output | 1 | Latched result was taken after settling |

## Verification
Checked on every cycle by assertions: the latch and its validity flag change only on a capture strobe; a capture marked valid had a full settle count behind it; the settle count is zero whenever the comparator is unpowered; an armed capture clears itself when it fires; low-supply ticks always capture; and no capture happens while no trigger is possible. The bench scenarios show the parts that depend on history: whether an `instrDone` lands in or after the write cycle, arm cancellation, coincident triggers, and the handoff from software-driven to hardware-driven resampling until recovery.

// File: rtl/supply_sense_pkg.sv
package supply_sense_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // write comparator result into the status latch
    logic power;     // comparator must be powered this cycle
  } senseStrobe_t;

  // Which trigger produced a capture (for readability of the control)
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_ARM  = 2'b01,
    SRC_TICK = 2'b10,
    SRC_BOTH = 2'b11
  } captureSrc_t;

endpackage

// File: rtl/supply_sense_ctrl.sv
module supply_sense_ctrl
  import supply_sense_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic         cfgHeavyLoad,
  input  logic         cfgDetEn,
  input  logic         instrDone,
  input  logic         tick2Hz,
  input  logic         latchedLow,
  output senseStrobe_t strb,
  output logic         heavyLoadQ
);

  logic        heavyLoad;
  logic        detEn;
  logic        armPending;
  logic        armFire;
  logic        tickFire;
  logic        heavyRise;
  logic        heavyClear;
  captureSrc_t src;

  assign heavyRise  = cfgWrEn && cfgHeavyLoad && !heavyLoad;
  assign heavyClear = cfgWrEn && !cfgHeavyLoad;

  // One-shot capture at the end of the instruction following entry
  assign armFire  = armPending && heavyLoad && instrDone;
  // Periodic capture: heavy-load mode, or hardware resample on low supply
  assign tickFire = tick2Hz && (heavyLoad || latchedLow);

  always_comb begin
    src = SRC_NONE;
    if (armFire && tickFire) src = SRC_BOTH;
    else if (armFire)        src = SRC_ARM;
    else if (tickFire)       src = SRC_TICK;
  end

  always_comb begin
    strb.capture = (src != SRC_NONE);
    strb.power   = detEn || heavyLoad || latchedLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heavyLoad <= 1'b0;
      detEn     <= 1'b0;
    end else if (cfgWrEn) begin
      heavyLoad <= cfgHeavyLoad;
      detEn     <= cfgDetEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   armPending <= 1'b0;
    else if (heavyRise)                          armPending <= 1'b1;
    else if (heavyClear)                         armPending <= 1'b0;
    else if (src == SRC_ARM || src == SRC_BOTH)  armPending <= 1'b0;
  end

  assign heavyLoadQ = heavyLoad;

  // R4 / R11: a fired arm never survives into the next cycle
  p_arm_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (armPending && heavyLoad && instrDone && !cfgWrEn) |=> !armPending);

  // R7: low supply plus a tick always yields a capture
  p_resample_r7: assert property (@(posedge clk) disable iff (!rstN)
    (latchedLow && tick2Hz) |-> strb.capture);

  // R6: no trigger source means no capture
  p_no_idle_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!heavyLoad && !latchedLow && !armPending) |-> !strb.capture);

  // R12: clearing heavy-load drops any pending arm
  p_cancel_r12: assert property (@(posedge clk) disable iff (!rstN)
    heavyClear |=> !armPending);

endmodule

// File: rtl/supply_sense_dp.sv
module supply_sense_dp
  import supply_sense_pkg::*;
#(
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic         clk,
  input  logic         rstN,
  input  senseStrobe_t strb,
  input  logic         cmpIn,
  output logic         statusLow,
  output logic         statusValid
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] settleCnt;
  logic             settled;

  assign settled = (settleCnt == CNT_MAX);

  // Settle timer: cleared while unpowered, saturates at the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              settleCnt <= '0;
    else if (!strb.power)   settleCnt <= '0;
    else if (!settled)      settleCnt <= settleCnt + 1'b1;
  end

  // Status latch and its validity flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusLow   <= 1'b0;
      statusValid <= 1'b0;
    end else if (strb.capture) begin
      statusLow   <= cmpIn;
      statusValid <= settled;
    end
  end

  // R5 / R6: the latch moves only on a capture strobe
  p_latch_on_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(statusLow) && $stable(statusValid)));

  // R9: a fresh valid flag requires the full window behind it
  p_valid_settled_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && settleCnt < CNT_MAX) |=> !statusValid);

  // R10: unpowered comparator restarts the window
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.power |=> (settleCnt == '0));

endmodule

// File: rtl/supply_sense_top.sv
module supply_sense_top
  import supply_sense_pkg::*;
#(
  parameter int SETTLE_CYCLES = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWrEn,
  input  logic cfgHeavyLoad,
  input  logic cfgDetEn,
  input  logic instrDone,
  input  logic tick2Hz,
  input  logic cmpIn,
  output logic cmpPower,
  output logic hiStabSel,
  output logic statusLow,
  output logic statusValid
);

  senseStrobe_t strb;
  logic         heavyLoadQ;

  supply_sense_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgHeavyLoad (cfgHeavyLoad),
    .cfgDetEn     (cfgDetEn),
    .instrDone    (instrDone),
    .tick2Hz      (tick2Hz),
    .latchedLow   (statusLow),
    .strb         (strb),
    .heavyLoadQ   (heavyLoadQ)
  );

  supply_sense_dp #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cmpIn       (cmpIn),
    .statusLow   (statusLow),
    .statusValid (statusValid)
  );

  assign cmpPower  = strb.power;
  assign hiStabSel = heavyLoadQ;

  // R2: regulator select tracks the written heavy-load bit
  p_histab_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (hiStabSel == $past(cfgHeavyLoad)));

  // R8: latched low supply keeps the comparator powered
  p_power_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusLow |-> cmpPower);

endmodule

// File: tb/supply_sense_top_test.sv
`timescale 1ns/1ps
module supply_sense_top_test;

  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgHeavyLoad = 0, cfgDetEn = 0;
  logic instrDone = 0, tick2Hz = 0, cmpIn = 0;
  logic cmpPower, hiStabSel, statusLow, statusValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supply_sense_top #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgHeavyLoad(cfgHeavyLoad),
    .cfgDetEn(cfgDetEn), .instrDone(instrDone), .tick2Hz(tick2Hz),
    .cmpIn(cmpIn), .cmpPower(cmpPower), .hiStabSel(hiStabSel),
    .statusLow(statusLow), .statusValid(statusValid)
  );

  // Row bits: wr hl de instr tick cmp | expLow expValid expHs expPower
  localparam int NVEC = 9;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b110101_0011,  // write HL=1 with instrDone same cycle: no capture
    10'b000101_1011,  // first later instrDone captures 1, not settled
    10'b000100_1011,  // arm consumed: no capture
    10'b000010_0011,  // tick in heavy-load captures 0
    10'b100000_0000,  // all off: power drops, select off
    10'b000011_0000,  // tick ignored
    10'b101000_0001,  // detector enable only: powered
    10'b000011_0001,  // tick still ignored with only detector enable
    10'b100000_0000   // all off again
  };
  localparam string VTAG [NVEC] = '{"R3", "R3", "R4", "R5", "R8", "R6", "R2", "R6", "R8"};

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, let one rising edge pass, return at the falling edge
  task automatic step(input logic wr, hl, de, ins, tk, cmp);
    cfgWrEn = wr; cfgHeavyLoad = hl; cfgDetEn = de;
    instrDone = ins; tick2Hz = tk; cmpIn = cmp;
    @(negedge clk);
    cfgWrEn = 0; instrDone = 0; tick2Hz = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "statusLow", statusLow, 1'b0);
    chk("R1", "statusValid", statusValid, 1'b0);
    chk("R1", "hiStabSel", hiStabSel, 1'b0);
    chk("R1", "cmpPower", cmpPower, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      chk(VTAG[v], "statusLow", statusLow, VEC[v][3]);
      chk(VTAG[v], "statusValid", statusValid, VEC[v][2]);
      chk(VTAG[v], "hiStabSel", hiStabSel, VEC[v][1]);
      chk(VTAG[v], "cmpPower", cmpPower, VEC[v][0]);
    end

    // R9: early capture invalid, later capture valid
    step(1, 1, 0, 0, 0, 0);
    idle(4);
    step(0, 0, 0, 0, 1, 1);
    chk("R9", "early statusValid", statusValid, 1'b0);
    chk("R9", "early statusLow", statusLow, 1'b1);
    idle(17);
    step(0, 0, 0, 0, 1, 1);
    chk("R9", "settled statusValid", statusValid, 1'b1);

    // R7: hardware resampling after software clears both bits
    step(1, 0, 0, 0, 0, 0);
    chk("R7", "cmpPower held", cmpPower, 1'b1);
    chk("R2", "hiStabSel cleared", hiStabSel, 1'b0);
    step(0, 0, 0, 0, 1, 1);
    chk("R7", "resample low", statusLow, 1'b1);
    chk("R7", "resample valid", statusValid, 1'b1);
    step(0, 0, 0, 0, 1, 0);
    chk("R7", "recovered", statusLow, 1'b0);
    chk("R7", "power released", cmpPower, 1'b0);

    // R10: window restarts after power loss
    step(1, 1, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 1, 0);
    chk("R10", "restart statusValid", statusValid, 1'b0);
    step(0, 0, 0, 1, 0, 1);
    chk("R3", "armed capture", statusLow, 1'b1);

    // R11: coincident arm and tick write once and consume the arm
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R11", "coincident capture", statusLow, 1'b0);
    step(0, 0, 0, 1, 0, 1);
    chk("R11", "arm consumed", statusLow, 1'b0);

    // R12: clearing heavy-load cancels the arm
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1);
    chk("R12", "cancelled arm", statusLow, 1'b0);
    chk("R12", "cmpPower off", cmpPower, 1'b0);

    finish_run();
  end

endmodule